// File: doc/BRIEF.md
# Segmented Parallel CRC-32 Generator

This block computes a 32-bit cyclic redundancy check over one fixed-length message. A start pulse captures the whole message into an internal register. The message is then cut into `SEGS` equal, contiguous segments. Each segment goes to its own bit-serial LFSR unit, and all units shift one bit per clock at the same time. The computation stage therefore takes `MSG_BITS/SEGS` cycles instead of `MSG_BITS`.

When the last segment bit has been consumed, the remainder of every unit except the last is multiplied by x^k modulo the generator. Here k is the number of message bits that follow that segment. Each multiply is a constant 32x32 GF(2) matrix computed at elaboration. The aligned remainders are XORed in a single registered combination cycle. The result equals the CRC of the whole message, so every legal segment count gives the same value.

The block reports progress in three ways:
- a busy flag while it works,
- a one-cycle done pulse when the result is ready,
- a CRC output that keeps its value until the next result replaces it.

Top module: `crc_seg_gen`

## Requirements
- R1: `crc_o` equals the CRC of the full message under these rules:
  - generator polynomial 0x04C11DB7;
  - register cleared to zero at start;
  - bits fed most significant first, with `msg_i[MSG_BITS-1]` the first bit;
  - no bit reflection and no final inversion.

  Consequences: an all-zero message gives 0x00000000. A message whose only set bit is bit 0 gives 0x04C11DB7. A message whose low 72 bits hold the ASCII string "123456789" (first character in the highest byte of that field, rest zero) gives 0x89A1897F.
- R2: For the same message, `SEGS` = 1, 2, 4 and 8 produce the same `crc_o`, and it equals a bit-serial reference computed over the whole message.
- R3: `done_o` goes high exactly `MSG_BITS/SEGS + 1` clock edges after the edge at which `start_i` is accepted. For the default `MSG_BITS` = 1024, that is 1025, 513, 257 and 129 edges for 1, 2, 4 and 8 segments.
- R4: `done_o` is high for exactly one cycle per accepted start. `crc_o` changes only in the cycle in which `done_o` rises, and otherwise holds its value.
- R5: `busy_o` is high from the edge that accepts `start_i` until the edge that raises `done_o`. That is `MSG_BITS/SEGS + 1` consecutive cycles, and `busy_o` is low while `done_o` is high.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running computation keeps its message and its timing.
- R7: While `rst` is high, and after it, until the first accepted start: `busy_o`, `done_o` and `crc_o` are all zero.
- R8: `msg_i` is sampled only on the edge that accepts `start_i`. Changing it while busy has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request; accepted only while not busy |
| msg_i | input | MSG_BITS | Message; bit MSG_BITS-1 is the first bit fed |
| busy_o | output | 1 | High while a computation is in progress |
| done_o | output | 1 | One-cycle pulse when crc_o is updated |
| crc_o | output | 32 | Final combined CRC, held until the next result |

## Verification
Four instances with 1, 2, 4 and 8 segments receive the same messages. Disagreement between them exposes a wrong alignment matrix for one segment position.

The message patterns each isolate a different fault:
- An all-zero message checks the clearing of every unit.
- A message with only the last bit set isolates the unaligned last segment.
- A message with only the first bit set exercises the longest alignment shift.
- The ASCII check string pins the bit order against a published value.
- All-ones and random messages compare against a whole-message serial reference.

Two further cases exercise the control path. A second start pulse during a run, and a change of the message input during a run, each have to leave both the result and the done timing untouched.

// File: rtl/crc_seg_pkg.sv
package crc_seg_pkg;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_COMB = 2'd2
  } seg_state_t;

  // Multiply a remainder by x modulo the generator.
  function automatic logic [CRC_W-1:0] crc_mul_x(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    r = {v[CRC_W-2:0], 1'b0};
    if (v[CRC_W-1]) r = r ^ CRC_POLY;
    return r;
  endfunction

  // Column j of the matrix holds x^(shift+j) mod G: the image of basis bit j.
  function automatic logic [CRC_W*CRC_W-1:0] crc_xpow_cols(input int shift);
    logic [CRC_W-1:0]       base;
    logic [CRC_W*CRC_W-1:0] cols;
    base = {{(CRC_W-1){1'b0}}, 1'b1};
    for (int i = 0; i < shift; i++) base = crc_mul_x(base);
    for (int j = 0; j < CRC_W; j++) begin
      cols[j*CRC_W +: CRC_W] = base;
      base = crc_mul_x(base);
    end
    return cols;
  endfunction

endpackage

// File: rtl/crc_seg_unit.sv
module crc_seg_unit
  import crc_seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] rem_o
);

  logic feedback;
  assign feedback = rem_o[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      rem_o <= '0;
    end else if (en_i) begin
      rem_o <= {rem_o[CRC_W-2:0], 1'b0} ^ (feedback ? CRC_POLY : '0);
    end
  end

endmodule

// File: rtl/crc_seg_align.sv
module crc_seg_align
  import crc_seg_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  logic [CRC_W-1:0] rem_i,
  output logic [CRC_W-1:0] aligned_o
);

  generate
    if (SHIFT == 0) begin : g_pass
      assign aligned_o = rem_i;
    end else begin : g_matrix
      localparam logic [CRC_W*CRC_W-1:0] COLS = crc_xpow_cols(SHIFT);
      always_comb begin
        aligned_o = '0;
        for (int j = 0; j < CRC_W; j++) begin
          if (rem_i[j]) aligned_o = aligned_o ^ COLS[j*CRC_W +: CRC_W];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/crc_seg_ctrl.sv
module crc_seg_ctrl
  import crc_seg_pkg::*;
#(
  parameter int SEG_BITS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic comb_o,
  output logic busy_o
);

  localparam int CNT_W = (SEG_BITS > 1) ? $clog2(SEG_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEG_BITS - 1);

  seg_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign load_o  = (state == ST_IDLE) && start_i;
  assign shift_o = (state == ST_RUN);
  assign comb_o  = (state == ST_COMB);
  assign busy_o  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start_i) state <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt == LAST) begin
            state <= ST_COMB;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: an accepted start makes the block busy on the next cycle.
  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  // R6: a start pulse during the run neither restarts nor stalls the count.
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (shift_o && start_i && cnt != LAST) |=> (shift_o && cnt == $past(cnt) + CNT_W'(1)));

  // R3: the combination cycle follows the last shift directly.
  a_r3_comb_after_last: assert property (@(posedge clk) disable iff (rst)
    (shift_o && cnt == LAST) |=> comb_o);

endmodule

// File: rtl/crc_seg_gen.sv
module crc_seg_gen
  import crc_seg_pkg::*;
#(
  parameter int MSG_BITS = 1024,
  parameter int SEGS     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [MSG_BITS-1:0] msg_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [CRC_W-1:0]    crc_o
);

  localparam int SEG_BITS = MSG_BITS / SEGS;

  logic                load;
  logic                shift;
  logic                comb;
  logic [MSG_BITS-1:0] msg_q;
  logic [CRC_W-1:0]    rem     [SEGS];
  logic [CRC_W-1:0]    aligned [SEGS];
  logic [CRC_W-1:0]    combined;

  crc_seg_ctrl #(.SEG_BITS(SEG_BITS)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .shift_o (shift),
    .comb_o  (comb),
    .busy_o  (busy_o)
  );

  // One shift register serves all segments: each unit taps its segment's top bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_q <= '0;
    end else if (load) begin
      msg_q <= msg_i;
    end else if (shift) begin
      msg_q <= {msg_q[MSG_BITS-2:0], 1'b0};
    end
  end

  generate
    for (genvar m = 0; m < SEGS; m++) begin : g_seg
      crc_seg_unit i_unit (
        .clk   (clk),
        .rst   (rst),
        .clr_i (load),
        .en_i  (shift),
        .bit_i (msg_q[MSG_BITS-1-m*SEG_BITS]),
        .rem_o (rem[m])
      );
      crc_seg_align #(.SHIFT(MSG_BITS - (m + 1) * SEG_BITS)) i_align (
        .rem_i     (rem[m]),
        .aligned_o (aligned[m])
      );
    end
  endgenerate

  always_comb begin
    combined = '0;
    for (int m = 0; m < SEGS; m++) combined = combined ^ aligned[m];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= comb;
      if (comb) crc_o <= combined;
    end
  end

  // R4: done is a single-cycle pulse.
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4: the result changes only together with done.
  a_r4_crc_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(crc_o));

  // R5: busy has dropped by the time done is presented.
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

endmodule

// File: tb/test_crc_seg_gen.sv
`timescale 1ns/1ps
module test_crc_seg_gen;

  localparam int MSG_BITS = 1024;
  localparam int NINST    = 4;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start_i = 1'b0;
  logic [MSG_BITS-1:0] msg_i = '0;
  logic                busy_w [NINST];
  logic                done_w [NINST];
  logic [31:0]         crc_w  [NINST];

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  crc_seg_gen #(.MSG_BITS(MSG_BITS), .SEGS(1)) i_crc_seg_gen_s1 (
    .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i),
    .busy_o(busy_w[0]), .done_o(done_w[0]), .crc_o(crc_w[0]));
  crc_seg_gen #(.MSG_BITS(MSG_BITS), .SEGS(2)) i_crc_seg_gen_s2 (
    .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i),
    .busy_o(busy_w[1]), .done_o(done_w[1]), .crc_o(crc_w[1]));
  crc_seg_gen #(.MSG_BITS(MSG_BITS), .SEGS(4)) i_crc_seg_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i),
    .busy_o(busy_w[2]), .done_o(done_w[2]), .crc_o(crc_w[2]));
  crc_seg_gen #(.MSG_BITS(MSG_BITS), .SEGS(8)) i_crc_seg_gen_s8 (
    .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i),
    .busy_o(busy_w[3]), .done_o(done_w[3]), .crc_o(crc_w[3]));

  function automatic logic [31:0] crc_ref(input logic [MSG_BITS-1:0] m);
    logic [31:0] r;
    logic        fb;
    r = '0;
    for (int i = MSG_BITS - 1; i >= 0; i--) begin
      fb = r[31] ^ m[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // mode 0: plain run; 1: extra start mid-run (R6); 2: msg_i changed mid-run (R8)
  task automatic run_case(input logic [MSG_BITS-1:0] m, input logic [31:0] exp,
                          input int mode, input string req);
    int lat    [NINST];
    int dcnt   [NINST];
    int bcnt   [NINST];
    int herr   [NINST];
    logic [31:0] got [NINST];
    for (int k = 0; k < NINST; k++) begin
      lat[k] = -1; dcnt[k] = 0; bcnt[k] = 0; herr[k] = 0; got[k] = '0;
    end
    @(negedge clk);
    msg_i   = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 1040; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (mode == 1 && cyc == 10) begin start_i = 1'b1; msg_i = ~m; end
      if (mode == 1 && cyc == 11) start_i = 1'b0;
      if (mode == 2 && cyc == 3) msg_i = ~m;
      for (int k = 0; k < NINST; k++) begin
        if (busy_w[k]) bcnt[k]++;
        if (done_w[k]) begin
          dcnt[k]++;
          if (lat[k] < 0) begin lat[k] = cyc; got[k] = crc_w[k]; end
        end else if (lat[k] >= 0 && crc_w[k] !== got[k]) begin
          herr[k]++;
        end
      end
    end
    for (int k = 0; k < NINST; k++) begin
      int seg = MSG_BITS >> k;
      chk(got[k] === exp, req, $sformatf("crc segs=%0d", 1 << k), got[k], exp);
      chk(lat[k] == seg + 1, "R3", $sformatf("done latency segs=%0d", 1 << k),
          lat[k], seg + 1);
      chk(dcnt[k] == 1, "R4", $sformatf("done pulse count segs=%0d", 1 << k),
          dcnt[k], 1);
      chk(herr[k] == 0, "R4", $sformatf("crc hold segs=%0d", 1 << k), herr[k], 0);
      chk(bcnt[k] == seg + 1, "R5", $sformatf("busy cycles segs=%0d", 1 << k),
          bcnt[k], seg + 1);
    end
    msg_i = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    for (int k = 0; k < NINST; k++) begin
      chk(busy_w[k] === 1'b0, "R7", "busy in reset", busy_w[k], 0);
      chk(done_w[k] === 1'b0, "R7", "done in reset", done_w[k], 0);
      chk(crc_w[k] === 32'h0, "R7", "crc in reset", crc_w[k], 0);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < NINST; k++) begin
      chk(busy_w[k] === 1'b0 && done_w[k] === 1'b0 && crc_w[k] === 32'h0,
          "R7", "idle after reset", crc_w[k], 0);
    end
  endtask

  task automatic t_zero();
    run_case('0, 32'h0000_0000, 0, "R1");
  endtask

  task automatic t_last_bit();
    logic [MSG_BITS-1:0] m = '0;
    m[0] = 1'b1;
    run_case(m, 32'h04C1_1DB7, 0, "R1");
  endtask

  task automatic t_first_bit();
    logic [MSG_BITS-1:0] m = '0;
    m[MSG_BITS-1] = 1'b1;
    run_case(m, crc_ref(m), 0, "R2");
  endtask

  task automatic t_check_string();
    logic [MSG_BITS-1:0] m = '0;
    m[71:0] = 72'h31_32_33_34_35_36_37_38_39;
    run_case(m, 32'h89A1_897F, 0, "R1");
  endtask

  task automatic t_ones();
    run_case('1, crc_ref('1), 0, "R2");
  endtask

  function automatic logic [MSG_BITS-1:0] rand_msg();
    logic [MSG_BITS-1:0] m;
    for (int w = 0; w < MSG_BITS / 32; w++) m[w*32 +: 32] = $urandom;
    return m;
  endfunction

  task automatic t_random(input int n);
    for (int i = 0; i < n; i++) begin
      logic [MSG_BITS-1:0] m = rand_msg();
      run_case(m, crc_ref(m), 0, "R2");
    end
  endtask

  task automatic t_start_while_busy();
    logic [MSG_BITS-1:0] m = rand_msg();
    run_case(m, crc_ref(m), 1, "R6");
  endtask

  task automatic t_msg_change();
    logic [MSG_BITS-1:0] m = rand_msg();
    run_case(m, crc_ref(m), 2, "R8");
  endtask

  initial begin
    t_reset();
    t_zero();
    t_last_bit();
    t_first_bit();
    t_check_string();
    t_ones();
    t_random(3);
    t_start_while_busy();
    t_msg_change();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule